// File: doc/BRIEF.md
# Tile Configuration Register Block

This block is the memory-mapped control space that the two processor cores of one tile share. It holds a 256-entry address translation table for each core, a test-and-set lock flag for each core, a tile identity word, a clock and reset control word, the thermal sensor control and readout words, one L2 setup word per core and one core setup word per core. Requests arrive on a simple single-cycle bus: a valid strobe, a write flag, the ID of the requesting core, a 13-bit byte offset and 32 bits of write data. Reads return their data exactly one cycle later. Writes get no response.

Some behaviour depends on who reads and when. The tile identity word carries the ID of the core that reads it. A read of a lock flag is also a write: it takes the lock if the lock is free. A core setup word combines twelve writable control bits with fourteen status bits that come from input ports. The sensor readout word packs both cores' 13-bit counters into one value. Sensor counters, core status, tile coordinates and the clock and cache hardware all live outside the block and connect through ports.

Each lock is a two-state machine, LK_CLEAR and LK_SET. A read in LK_CLEAR moves it to LK_SET (the take transition). Any write moves it back to LK_CLEAR (the release transition). A read in LK_SET leaves it there. The response path is a second two-state machine, RS_IDLE and RS_VALID. A read request moves it to RS_VALID for one cycle. When no read request arrives it falls back to RS_IDLE.

Top module: `tile_cfg_regs`

## Requirements
- R1: A read request gives a response one cycle later: `rsp_valid_o` is high for that cycle and `rsp_rdata_o` holds the data. A write request never gives a response.
- R2: The translation tables sit at byte offsets 0x800–0xFF8 (core 0) and 0x1000–0x17F8 (core 1), one entry every 8 bytes. The entry index is offset bits 10:3. Each entry stores the low 22 bits of the write data. The two tables are independent.
- R3: A read of the core-0 lock (0x200) or the core-1 lock (0x400) returns 1 and sets the flag if the flag was clear. If the flag was already set, the read returns 0 and the flag stays set.
- R4: Any write to a lock offset clears that flag, whatever the data. The two flags are independent.
- R5: A read of offset 0x100 returns the tile y coordinate in bits 10:7, the tile x coordinate in bits 6:3 and the reading core's ID in bits 2:0.
- R6: The clock/reset word at 0x080 stores 26 bits. Bit 0 resets core 0 (`core_rst_o[0]`), bit 1 resets core 1, bit 2 resets core 0's L2 (`l2_rst_o[0]`), bit 3 resets core 1's L2. All 26 bits appear on `clk_ctl_o`.
- R7: The sensor control word at 0x040 stores 14 bits and drives `sens_ctl_o`. Bit 13 is the enable and bits 12:0 are the preset value. It applies to both cores.
- R8: A read of 0x048 returns core 0's 13-bit counter in bits 25:13 and core 1's counter in bits 12:0.
- R9: The L2 setup words at 0x020 (core 0) and 0x028 (core 1) store 14 bits each. Bit 0 of each is that core's cache enable, driven on `l2_en_o`.
- R10: The core setup words at 0x010 (core 0) and 0x018 (core 1) read back as 26 bits. Bits 11:0 are writable and drive `core_cfg0_o`/`core_cfg1_o`. Bits 25:12 show that core's status input. Writes to bits 25:12 have no effect.
- R11: An offset that maps to no register reads as zero, and a write to it changes nothing. This covers offsets whose bits 2:0 are not zero, and offsets whose bits 12:11 are both 1. Bits above a register's width always read as zero.
- R12: After reset, every stored register and every table entry is zero. Both locks are clear and both L2 enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tile_x_i | input | 4 | Tile x coordinate (static) |
| tile_y_i | input | 4 | Tile y coordinate (static) |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_core_i | input | 1 | ID of the requesting core |
| req_addr_i | input | 13 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| core_stat0_i | input | 14 | Core 0 status bits |
| core_stat1_i | input | 14 | Core 1 status bits |
| sens_cnt0_i | input | 13 | Core 0 sensor counter |
| sens_cnt1_i | input | 13 | Core 1 sensor counter |
| clk_ctl_o | output | 26 | Clock/reset control word |
| core_rst_o | output | 2 | Per-core reset |
| l2_rst_o | output | 2 | Per-core L2 reset |
| sens_ctl_o | output | 14 | Sensor enable and preset |
| l2_cfg0_o | output | 14 | Core 0 L2 setup word |
| l2_cfg1_o | output | 14 | Core 1 L2 setup word |
| l2_en_o | output | 2 | Per-core L2 enable |
| core_cfg0_o | output | 12 | Core 0 writable setup bits |
| core_cfg1_o | output | 12 | Core 1 writable setup bits |

## Verification
The bench targets the following corner cases:

- Back-to-back reads of one lock. A design that returned the old flag value, or that failed to set the flag on the first read, would either grant the lock twice or never grant it.
- Writes to the first and last entries of both tables. A decoder that dropped an index bit or confused the two windows would show up as a changed entry in the table that was not written.
- The identity word read by each core in turn, and a core setup word written with all ones. A design that latched the core ID or let writes reach the status bits would return the wrong ID or lose the status pattern.
- Misaligned offsets, gaps between registers, and the window above core 1's table. Each must read as zero and must not disturb any stored state; a design that aliased any of them onto a register would fail these checks.

// File: rtl/tcfg_pkg.sv
`timescale 1ns/1ps
package tcfg_pkg;

    localparam int ADDR_W    = 13;
    localparam int DATA_W    = 32;
    localparam int TBL_DEPTH = 256;
    localparam int TBL_W     = 22;
    localparam int TBL_NUM   = 2;
    localparam int IDX_W     = $clog2(TBL_DEPTH);
    localparam int CLK_W     = 26;
    localparam int SCTL_W    = 14;
    localparam int CNT_W     = 13;
    localparam int L2_W      = 14;
    localparam int CCF_RW_W  = 12;
    localparam int CCF_ST_W  = 14;
    localparam int COORD_W   = 4;
    localparam int CID_W     = 3;
    localparam int ALIGN_W   = 3;

    localparam logic [ADDR_W-1:0] OFF_CCF0  = 13'h010;
    localparam logic [ADDR_W-1:0] OFF_CCF1  = 13'h018;
    localparam logic [ADDR_W-1:0] OFF_L2C0  = 13'h020;
    localparam logic [ADDR_W-1:0] OFF_L2C1  = 13'h028;
    localparam logic [ADDR_W-1:0] OFF_SCTL  = 13'h040;
    localparam logic [ADDR_W-1:0] OFF_SRD   = 13'h048;
    localparam logic [ADDR_W-1:0] OFF_CLK   = 13'h080;
    localparam logic [ADDR_W-1:0] OFF_TILE  = 13'h100;
    localparam logic [ADDR_W-1:0] OFF_LOCK0 = 13'h200;
    localparam logic [ADDR_W-1:0] OFF_LOCK1 = 13'h400;

    typedef enum logic [3:0] {
        T_NONE, T_TBL0, T_TBL1, T_LOCK0, T_LOCK1, T_TILE, T_CLK,
        T_SCTL, T_SRD, T_L2C0, T_L2C1, T_CCF0, T_CCF1
    } tgt_e;

    typedef enum logic { LK_CLEAR, LK_SET } lock_st_e;
    typedef enum logic { RS_IDLE, RS_VALID } rsp_st_e;

endpackage

// File: rtl/tcfg_decode.sv
`timescale 1ns/1ps
module tcfg_decode
    import tcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output tgt_e              tgt_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic aligned;
    assign aligned = (addr_i[ALIGN_W-1:0] == '0);
    assign idx_o   = addr_i[ALIGN_W +: IDX_W];

    always_comb begin
        tgt_o = T_NONE;
        if (aligned) begin
            unique case (addr_i[ADDR_W-1 -: 2])
                2'b01: tgt_o = T_TBL0;
                2'b10: tgt_o = T_TBL1;
                2'b00: begin
                    case (addr_i)
                        OFF_CCF0:  tgt_o = T_CCF0;
                        OFF_CCF1:  tgt_o = T_CCF1;
                        OFF_L2C0:  tgt_o = T_L2C0;
                        OFF_L2C1:  tgt_o = T_L2C1;
                        OFF_SCTL:  tgt_o = T_SCTL;
                        OFF_SRD:   tgt_o = T_SRD;
                        OFF_CLK:   tgt_o = T_CLK;
                        OFF_TILE:  tgt_o = T_TILE;
                        OFF_LOCK0: tgt_o = T_LOCK0;
                        OFF_LOCK1: tgt_o = T_LOCK1;
                        default:   tgt_o = T_NONE;
                    endcase
                end
                default: tgt_o = T_NONE;
            endcase
        end
    end

    // R11: misaligned offsets never decode
    always_comb begin
        if (!aligned) a_r11_misaligned_none: assert (tgt_o == T_NONE);
    end

endmodule

// File: rtl/tcfg_xlat_tables.sv
`timescale 1ns/1ps
module tcfg_xlat_tables
    import tcfg_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    parameter int WIDTH = TBL_W,
    parameter int NUM   = TBL_NUM,
    localparam int IW   = $clog2(DEPTH)
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            wr_en_i,
    input  logic [IW-1:0]             idx_i,
    input  logic [WIDTH-1:0]          wr_data_i,
    output logic [NUM-1:0][WIDTH-1:0] rd_data_o
);

    for (genvar t = 0; t < NUM; t++) begin : g_tbl
        logic [WIDTH-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
            end else if (wr_en_i[t]) begin
                mem[idx_i] <= wr_data_i;
            end
        end

        assign rd_data_o[t] = mem[idx_i];

        // R2: a written entry holds the written value on the next cycle
        a_r2_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i[t] |=> (mem[$past(idx_i)] == $past(wr_data_i)));
    end

endmodule

// File: rtl/tcfg_lock.sv
`timescale 1ns/1ps
module tcfg_lock
    import tcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic wr_i,
    output logic grant_o
);

    lock_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLEAR: if (rd_i) state_d = LK_SET;
            LK_SET:   if (wr_i) state_d = LK_CLEAR;
            default:  state_d = LK_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LK_CLEAR: grant_o = 1'b1;
            LK_SET:   grant_o = 1'b0;
            default:  grant_o = 1'b0;
        endcase
    end

    a_r3_take_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && state_q == LK_CLEAR) |=> (state_q == LK_SET));

    a_r3_stay_when_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && state_q == LK_SET) |=> (state_q == LK_SET));

    a_r4_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (state_q == LK_CLEAR));

endmodule

// File: rtl/tile_cfg_regs.sv
`timescale 1ns/1ps
module tile_cfg_regs
    import tcfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COORD_W-1:0]  tile_x_i,
    input  logic [COORD_W-1:0]  tile_y_i,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic                req_core_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    output logic                rsp_valid_o,
    output logic [DATA_W-1:0]   rsp_rdata_o,
    input  logic [CCF_ST_W-1:0] core_stat0_i,
    input  logic [CCF_ST_W-1:0] core_stat1_i,
    input  logic [CNT_W-1:0]    sens_cnt0_i,
    input  logic [CNT_W-1:0]    sens_cnt1_i,
    output logic [CLK_W-1:0]    clk_ctl_o,
    output logic [1:0]          core_rst_o,
    output logic [1:0]          l2_rst_o,
    output logic [SCTL_W-1:0]   sens_ctl_o,
    output logic [L2_W-1:0]     l2_cfg0_o,
    output logic [L2_W-1:0]     l2_cfg1_o,
    output logic [1:0]          l2_en_o,
    output logic [CCF_RW_W-1:0] core_cfg0_o,
    output logic [CCF_RW_W-1:0] core_cfg1_o
);

    localparam int NCORE = 2;

    logic wr_go, rd_go;
    assign wr_go = req_valid_i &&  req_write_i;
    assign rd_go = req_valid_i && !req_write_i;

    tgt_e             tgt;
    logic [IDX_W-1:0] idx;

    tcfg_decode u_decode (
        .addr_i (req_addr_i),
        .tgt_o  (tgt),
        .idx_o  (idx)
    );

    // translation tables
    logic [TBL_NUM-1:0]            tbl_we;
    logic [TBL_NUM-1:0][TBL_W-1:0] tbl_rd;

    assign tbl_we[0] = wr_go && (tgt == T_TBL0);
    assign tbl_we[1] = wr_go && (tgt == T_TBL1);

    tcfg_xlat_tables u_tables (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (tbl_we),
        .idx_i     (idx),
        .wr_data_i (req_wdata_i[TBL_W-1:0]),
        .rd_data_o (tbl_rd)
    );

    // test-and-set locks
    logic [NCORE-1:0] lock_hit, lock_grant;
    assign lock_hit[0] = (tgt == T_LOCK0);
    assign lock_hit[1] = (tgt == T_LOCK1);

    for (genvar g = 0; g < NCORE; g++) begin : g_lock
        tcfg_lock u_lock (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_i    (rd_go && lock_hit[g]),
            .wr_i    (wr_go && lock_hit[g]),
            .grant_o (lock_grant[g])
        );
    end

    // plain stored registers
    logic [CLK_W-1:0]                clk_q;
    logic [SCTL_W-1:0]               sctl_q;
    logic [NCORE-1:0][L2_W-1:0]      l2c_q;
    logic [NCORE-1:0][CCF_RW_W-1:0]  ccf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= '0;
            sctl_q <= '0;
            l2c_q  <= '0;
            ccf_q  <= '0;
        end else if (wr_go) begin
            case (tgt)
                T_CLK:   clk_q    <= req_wdata_i[CLK_W-1:0];
                T_SCTL:  sctl_q   <= req_wdata_i[SCTL_W-1:0];
                T_L2C0:  l2c_q[0] <= req_wdata_i[L2_W-1:0];
                T_L2C1:  l2c_q[1] <= req_wdata_i[L2_W-1:0];
                T_CCF0:  ccf_q[0] <= req_wdata_i[CCF_RW_W-1:0];
                T_CCF1:  ccf_q[1] <= req_wdata_i[CCF_RW_W-1:0];
                default: ;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^req_wdata_i[DATA_W-1:CLK_W];

    // read multiplexer
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        unique case (tgt)
            T_TBL0:  rd_mux = DATA_W'(tbl_rd[0]);
            T_TBL1:  rd_mux = DATA_W'(tbl_rd[1]);
            T_LOCK0: rd_mux = DATA_W'(lock_grant[0]);
            T_LOCK1: rd_mux = DATA_W'(lock_grant[1]);
            T_TILE:  rd_mux = DATA_W'({tile_y_i, tile_x_i, CID_W'(req_core_i)});
            T_CLK:   rd_mux = DATA_W'(clk_q);
            T_SCTL:  rd_mux = DATA_W'(sctl_q);
            T_SRD:   rd_mux = DATA_W'({sens_cnt0_i, sens_cnt1_i});
            T_L2C0:  rd_mux = DATA_W'(l2c_q[0]);
            T_L2C1:  rd_mux = DATA_W'(l2c_q[1]);
            T_CCF0:  rd_mux = DATA_W'({core_stat0_i, ccf_q[0]});
            T_CCF1:  rd_mux = DATA_W'({core_stat1_i, ccf_q[1]});
            T_NONE:  rd_mux = '0;
            default: rd_mux = '0;
        endcase
    end

    // response state machine
    rsp_st_e rs_q, rs_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        unique case (rs_q)
            RS_IDLE:  rs_d = rd_go ? RS_VALID : RS_IDLE;
            RS_VALID: rs_d = rd_go ? RS_VALID : RS_IDLE;
            default:  rs_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q    <= RS_IDLE;
            rdata_q <= '0;
        end else begin
            rs_q    <= rs_d;
            rdata_q <= rd_go ? rd_mux : '0;
        end
    end

    always_comb begin
        unique case (rs_q)
            RS_VALID: begin rsp_valid_o = 1'b1; rsp_rdata_o = rdata_q; end
            default:  begin rsp_valid_o = 1'b0; rsp_rdata_o = '0;      end
        endcase
    end

    // outputs
    assign clk_ctl_o   = clk_q;
    assign core_rst_o  = clk_q[1:0];
    assign l2_rst_o    = clk_q[3:2];
    assign sens_ctl_o  = sctl_q;
    assign l2_cfg0_o   = l2c_q[0];
    assign l2_cfg1_o   = l2c_q[1];
    assign l2_en_o     = {l2c_q[1][0], l2c_q[0][0]};
    assign core_cfg0_o = ccf_q[0];
    assign core_cfg1_o = ccf_q[1];

    a_r1_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rsp_valid_o);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && !req_write_i));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_rdata_o[DATA_W-1:CLK_W] == '0));

    a_r9_l2en_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l2_en_o) |-> $past(wr_go));

    a_r6_reset_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_rst_o) |-> $past(wr_go && tgt == T_CLK));

endmodule

// File: tb/test_tile_cfg_regs.sv
`timescale 1ns/1ps
module test_tile_cfg_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tile_x = 4'd5, tile_y = 4'd2;
    logic        req_valid = 1'b0, req_write = 1'b0, req_core = 1'b0;
    logic [12:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [13:0] stat0 = 14'h2AAA, stat1 = 14'h1555;
    logic [12:0] cnt0 = 13'h1ABC, cnt1 = 13'h0123;
    logic [25:0] clk_ctl;
    logic [1:0]  core_rst, l2_rst, l2_en;
    logic [13:0] sens_ctl, l2_cfg0, l2_cfg1;
    logic [11:0] core_cfg0, core_cfg1;

    always #2 clk = ~clk;

    tile_cfg_regs i_tile_cfg_regs (
        .clk(clk), .rst_n(rst_n), .tile_x_i(tile_x), .tile_y_i(tile_y),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_core_i(req_core),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .core_stat0_i(stat0), .core_stat1_i(stat1),
        .sens_cnt0_i(cnt0), .sens_cnt1_i(cnt1),
        .clk_ctl_o(clk_ctl), .core_rst_o(core_rst), .l2_rst_o(l2_rst),
        .sens_ctl_o(sens_ctl), .l2_cfg0_o(l2_cfg0), .l2_cfg1_o(l2_cfg1),
        .l2_en_o(l2_en), .core_cfg0_o(core_cfg0), .core_cfg1_o(core_cfg1)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic core, logic [12:0] addr, logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_core = core;
        req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic core, logic [12:0] addr, logic [31:0] exp, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_core = core;
        req_addr = addr; req_wdata = 32'hDEAD_BEEF;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R1 unexpected response act=%h exp=none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rsp_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 l2_en", 32'(l2_en), 32'h0);
        chk("R12 core_rst", 32'(core_rst), 32'h0);
        chk("R12 sens_ctl", 32'(sens_ctl), 32'h0);
        rd(0, 13'h080, 32'h0, "R12 clk word");
        rd(0, 13'h800, 32'h0, "R12 table0 entry");
        rd(1, 13'h010, {18'h0, stat0, 12'h0} >> 0 == 0 ? 32'h0 : (32'(stat0) << 12), "R12 core cfg0");

        // R2: tables
        wr(0, 13'h800, 32'hFFFF_FFFF);
        wr(1, 13'h0FF8, 32'h0012_3456);
        wr(0, 13'h1000, 32'h0000_0ABC);
        wr(1, 13'h17F8, 32'h002A_AAAA);
        rd(0, 13'h800, 32'h003F_FFFF, "R2 t0 first");
        rd(1, 13'h0FF8, 32'h0012_3456, "R2 t0 last");
        rd(0, 13'h1000, 32'h0000_0ABC, "R2 t1 first");
        rd(1, 13'h17F8, 32'h002A_AAAA, "R2 t1 last");
        rd(0, 13'h808, 32'h0, "R2 neighbour untouched");

        // R3 / R4: locks
        rd(0, 13'h200, 32'h1, "R3 lock0 take");
        rd(1, 13'h200, 32'h0, "R3 lock0 busy");
        rd(1, 13'h400, 32'h1, "R3 lock1 independent");
        wr(1, 13'h200, 32'h0);
        rd(1, 13'h200, 32'h1, "R4 lock0 released");
        rd(0, 13'h400, 32'h0, "R4 lock1 still held");

        // R5: tile identity
        rd(0, 13'h100, (32'd2 << 7) | (32'd5 << 3) | 32'd0, "R5 core0 id");
        rd(1, 13'h100, (32'd2 << 7) | (32'd5 << 3) | 32'd1, "R5 core1 id");

        // R6: clock/reset word
        wr(0, 13'h080, 32'hFFFF_FFFF);
        chk("R6 core_rst all", 32'(core_rst), 32'h3);
        chk("R6 l2_rst all", 32'(l2_rst), 32'h3);
        rd(0, 13'h080, 32'h03FF_FFFF, "R6 clk readback");
        wr(1, 13'h080, 32'h0000_0005);
        chk("R6 core_rst bit0", 32'(core_rst), 32'h1);
        chk("R6 l2_rst bit2", 32'(l2_rst), 32'h1);
        chk("R6 clk_ctl", 32'(clk_ctl), 32'h5);

        // R7 / R8: sensor
        wr(0, 13'h040, 32'hFFFF_FFFF);
        chk("R7 sens_ctl", 32'(sens_ctl), 32'h3FFF);
        rd(1, 13'h040, 32'h0000_3FFF, "R7 readback");
        rd(0, 13'h048, (32'(cnt0) << 13) | 32'(cnt1), "R8 packed counters");

        // R9: L2 setup
        wr(0, 13'h020, 32'h0000_0001);
        chk("R9 l2_en core0", 32'(l2_en), 32'h1);
        wr(1, 13'h028, 32'hFFFF_FFFF);
        chk("R9 l2_en both", 32'(l2_en), 32'h3);
        chk("R9 l2_cfg1", 32'(l2_cfg1), 32'h3FFF);
        rd(1, 13'h028, 32'h0000_3FFF, "R9 readback");

        // R10: core setup
        wr(0, 13'h010, 32'hFFFF_FFFF);
        wr(1, 13'h018, 32'h0000_0000);
        chk("R10 core_cfg0", 32'(core_cfg0), 32'hFFF);
        rd(0, 13'h010, (32'(stat0) << 12) | 32'hFFF, "R10 cfg0 mix");
        rd(1, 13'h018, (32'(stat1) << 12), "R10 cfg1 status only");

        // R11: undecoded space
        wr(0, 13'h008, 32'hFFFF_FFFF);
        rd(0, 13'h008, 32'h0, "R11 gap");
        rd(0, 13'h801, 32'h0, "R11 misaligned");
        wr(0, 13'h1800, 32'h0000_0777);
        rd(0, 13'h1800, 32'h0, "R11 top window");
        rd(0, 13'h800, 32'h003F_FFFF, "R11 t0 not aliased");
        rd(0, 13'h030, 32'h0, "R11 hole");

        // R1: no response to writes, none outstanding
        wr(0, 13'h020, 32'h0);
        repeat (3) @(negedge clk);
        chk("R1 all answered", 32'(exp_q.size()), 32'h0);
        report();
    end

endmodule